// File: doc/BRIEF.md
# Forty-Bit Multiply-Accumulate Unit

This block is an execution unit that multiplies signed operands and adds the product into a single internal 40-bit accumulator. Upstream logic supplies a decoded command. The command carries a 4-bit operation code, a 3-bit accumulator index, a 32-bit multiplicand, a 32-bit multiplier and the result of the condition check. Instruction fetch, register reads and condition evaluation all take place outside the block.

The multiply is iterative and consumes eight multiplier bits per cycle. It stops as soon as the unconsumed upper part of the multiplier is pure sign extension. Small multipliers therefore finish in one cycle, and a full 32-bit multiplier needs four. A `busy` output covers the variable latency, and `done` pulses once when the sum lands in the accumulator. Halfword variants pick a signed 16-bit half of each operand. The packed variant multiplies both halfword pairs in parallel and adds both products. Software-style access to the accumulator goes through a 40-bit read-out, a synchronous load port and a synchronous clear port. Every sum wraps modulo 2^40, and no flags are produced.

Top module: `mac40_unit`

## Requirements
- R1: After reset, `acc_out` is zero and `busy`, `done` and `err` are low.
- R2: Operation code 4'b0000 (full word) adds the low 40 bits of the signed 32x32 product of `cmd_mcand` and `cmd_mplier` to the accumulator, and keeps only the low 40 bits of the sum.
- R3: Operation codes 4'b1100, 4'b1101, 4'b1110 and 4'b1111 select halfwords. Code bit 1 picks the multiplicand half and code bit 0 picks the multiplier half, where 0 means bits [15:0] and 1 means bits [31:16]. The signed 16x16 product is sign-extended to 40 bits and accumulated.
- R4: Operation code 4'b1000 (packed) forms two signed 16x16 products, one from the bits [15:0] pair and one from the bits [31:16] pair. Both are sign-extended and added to the accumulator.
- R5: A command is accepted when `cmd_valid` is high while `busy` is low. An accepted legal command with `cmd_cond` low leaves the accumulator unchanged and raises none of `busy`, `done` or `err`.
- R6: An accepted command with any other operation code, or with `cmd_acc` non-zero, raises `err` for exactly the next cycle. It does not raise `busy` and leaves the accumulator unchanged, whatever the value of `cmd_cond`.
- R7: An accepted legal command with `cmd_cond` high holds `busy` for N cycles. N is the smallest k in 1..4 such that bits [31:8k] of the effective multiplier all equal its bit 31. The effective multiplier is the sign-extended selected half for the halfword codes. For the packed code, N is the larger of the two halves' counts. In the cycle after the last busy cycle, `done` is high for one cycle and `acc_out` shows the new sum.
- R8: Commands presented while `busy` is high are ignored.
- R9: When `busy` is low, `acc_clr` zeroes the accumulator on the next edge. Otherwise `acc_wr_en` loads `acc_wr_data` on the next edge. Clear takes priority over load.
- R10: `acc_wr_en` and `acc_clr` have no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 4 | Operation code |
| cmd_acc | input | 3 | Accumulator index, only 0 is legal |
| cmd_mcand | input | 32 | Multiplicand operand |
| cmd_mplier | input | 32 | Multiplier operand |
| cmd_cond | input | 1 | Condition check passed |
| acc_wr_en | input | 1 | Load accumulator |
| acc_wr_data | input | 40 | Load value |
| acc_clr | input | 1 | Clear accumulator |
| acc_out | output | 40 | Accumulator value |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle illegal-command pulse |

## Verification
The assertions run on every cycle. They check that an illegal command produces a one-cycle error without starting a multiply or touching the accumulator. They check that a failed condition never starts a multiply, and that busy never lasts longer than four cycles. They also check that the accumulator stays frozen while busy except at the completing edge, that done is a single pulse following busy, and that clear and load act on the next edge. Arithmetic correctness has to come from the bench's scenarios. These cover the signed product values of each operation code, the wrap at 40 bits, and the exact cycle count each multiplier magnitude produces. They also include stray commands, loads and clears issued during a multiply, which must leave no trace.

// File: rtl/mac40_pkg.sv
`timescale 1ns/1ps
package mac40_pkg;
   localparam int CODE_W = 4;

   typedef enum logic [CODE_W-1:0] {
      OP_WORD = 4'b0000,
      OP_DUAL = 4'b1000,
      OP_BB   = 4'b1100,
      OP_BT   = 4'b1101,
      OP_TB   = 4'b1110,
      OP_TT   = 4'b1111
   } mac_op_e;
endpackage

// File: rtl/mac40_decode.sv
`timescale 1ns/1ps
// Operand routing: maps the operation code onto two multiplier lanes.
module mac40_decode
   import mac40_pkg::*;
#(
   parameter int OP_W = 32
) (
   input  logic [CODE_W-1:0]       op,
   input  logic [OP_W-1:0]         mcand,
   input  logic [OP_W-1:0]         mplier,
   output logic                    known,
   output logic [1:0][OP_W-1:0]    lane_a,
   output logic [1:0][OP_W-1:0]    lane_b
);
   localparam int HALF = OP_W / 2;

   function automatic logic [OP_W-1:0] hext(input logic [HALF-1:0] h);
      return OP_W'($signed(h));
   endfunction

   always_comb begin
      lane_a = '0;
      lane_b = '0;
      known  = 1'b1;
      case (op)
         OP_WORD: begin
            lane_a[0] = mcand;
            lane_b[0] = mplier;
         end
         OP_DUAL: begin
            lane_a[0] = hext(mcand[HALF-1:0]);
            lane_b[0] = hext(mplier[HALF-1:0]);
            lane_a[1] = hext(mcand[OP_W-1:HALF]);
            lane_b[1] = hext(mplier[OP_W-1:HALF]);
         end
         OP_BB, OP_BT, OP_TB, OP_TT: begin
            // bit 1 picks the multiplicand half, bit 0 the multiplier half
            lane_a[0] = op[1] ? hext(mcand[OP_W-1:HALF])  : hext(mcand[HALF-1:0]);
            lane_b[0] = op[0] ? hext(mplier[OP_W-1:HALF]) : hext(mplier[HALF-1:0]);
         end
         default: known = 1'b0;
      endcase
   end
endmodule

// File: rtl/mac40_lane.sv
`timescale 1ns/1ps
// One iterative signed multiplier lane, DIGIT_W multiplier bits per step,
// arithmetic kept modulo 2^ACC_W.
module mac40_lane #(
   parameter int OP_W    = 32,
   parameter int ACC_W   = 40,
   parameter int DIGIT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [OP_W-1:0]  mcand,
   input  logic [OP_W-1:0]  mplier,
   output logic             fin,
   output logic [ACC_W-1:0] res
);
   logic [OP_W-1:0]    m_q, m_nxt;
   logic [ACC_W-1:0]   sh_q, sh_nxt;
   logic [ACC_W-1:0]   p_q, p_nxt;
   logic [DIGIT_W-1:0] digit;

   always_comb begin
      digit  = m_q[DIGIT_W-1:0];
      p_nxt  = p_q + sh_q * ACC_W'(digit);
      m_nxt  = $signed(m_q) >>> DIGIT_W;
      sh_nxt = sh_q << DIGIT_W;
      // remaining multiplier is 0 or -1: fold it in as a correction
      fin    = (m_nxt == '0) || (&m_nxt);
      res    = m_nxt[OP_W-1] ? (p_nxt - sh_nxt) : p_nxt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_q  <= '0;
         sh_q <= '0;
         p_q  <= '0;
      end else if (load) begin
         m_q  <= mplier;
         sh_q <= ACC_W'($signed(mcand));
         p_q  <= '0;
      end else if (step) begin
         m_q  <= m_nxt;
         sh_q <= sh_nxt;
         p_q  <= p_nxt;
      end
   end
endmodule

// File: rtl/mac40_acc.sv
`timescale 1ns/1ps
// Accumulator register: clear, load, wrapping add.
module mac40_acc #(
   parameter int ACC_W = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr,
   input  logic [ACC_W-1:0] wr_data,
   input  logic             add_en,
   input  logic [ACC_W-1:0] add_val,
   output logic [ACC_W-1:0] acc_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)      acc_q <= '0;
      else if (clr)    acc_q <= '0;
      else if (wr)     acc_q <= wr_data;
      else if (add_en) acc_q <= acc_q + add_val;
   end
endmodule

// File: rtl/mac40_unit.sv
`timescale 1ns/1ps
module mac40_unit
   import mac40_pkg::*;
#(
   parameter int ACC_W   = 40,
   parameter int OP_W    = 32,
   parameter int DIGIT_W = 8,
   parameter int SEL_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [CODE_W-1:0]  cmd_op,
   input  logic [SEL_W-1:0]   cmd_acc,
   input  logic [OP_W-1:0]    cmd_mcand,
   input  logic [OP_W-1:0]    cmd_mplier,
   input  logic               cmd_cond,
   input  logic               acc_wr_en,
   input  logic [ACC_W-1:0]   acc_wr_data,
   input  logic               acc_clr,
   output logic [ACC_W-1:0]   acc_out,
   output logic               busy,
   output logic               done,
   output logic               err
);
   localparam int NLANE = 2;

   if (OP_W % DIGIT_W != 0) begin : g_bad_digit
      $error("OP_W must be a multiple of DIGIT_W");
   end
   if (OP_W % 2 != 0) begin : g_bad_half
      $error("OP_W must be even");
   end
   if (ACC_W < OP_W) begin : g_bad_acc
      $error("ACC_W must be at least OP_W");
   end

   logic                        busy_q, done_q, err_q;
   logic                        known, legal, accept, start, finish;
   logic [1:0][OP_W-1:0]        lane_a, lane_b;
   logic [NLANE-1:0]            lane_fin;
   logic [NLANE-1:0][ACC_W-1:0] lane_res;
   logic [ACC_W-1:0]            add_val;

   mac40_decode #(.OP_W(OP_W)) u_dec (
      .op     (cmd_op),
      .mcand  (cmd_mcand),
      .mplier (cmd_mplier),
      .known  (known),
      .lane_a (lane_a),
      .lane_b (lane_b)
   );

   assign accept = cmd_valid && !busy_q;
   assign legal  = known && (cmd_acc == '0);
   assign start  = accept && legal && cmd_cond;
   assign finish = busy_q && (&lane_fin);

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      mac40_lane #(.OP_W(OP_W), .ACC_W(ACC_W), .DIGIT_W(DIGIT_W)) u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .load   (start),
         .step   (busy_q),
         .mcand  (lane_a[g]),
         .mplier (lane_b[g]),
         .fin    (lane_fin[g]),
         .res    (lane_res[g])
      );
   end

   always_comb begin
      add_val = '0;
      for (int i = 0; i < NLANE; i++) add_val = add_val + lane_res[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (start)       busy_q <= 1'b1;
         else if (finish) busy_q <= 1'b0;
         done_q <= finish;
         err_q  <= accept && !legal;
      end
   end

   mac40_acc #(.ACC_W(ACC_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (acc_clr && !busy_q),
      .wr      (acc_wr_en && !busy_q),
      .wr_data (acc_wr_data),
      .add_en  (finish),
      .add_val (add_val),
      .acc_q   (acc_out)
   );

   assign busy = busy_q;
   assign done = done_q;
   assign err  = err_q;
endmodule

// File: rtl/mac40_chk.sv
`timescale 1ns/1ps
module mac40_chk #(
   parameter int ACC_W   = 40,
   parameter int OP_W    = 32,
   parameter int DIGIT_W = 8,
   parameter int SEL_W   = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [3:0]       cmd_op,
   input logic [SEL_W-1:0] cmd_acc,
   input logic             cmd_cond,
   input logic             acc_wr_en,
   input logic [ACC_W-1:0] acc_wr_data,
   input logic             acc_clr,
   input logic [ACC_W-1:0] acc_out,
   input logic             busy,
   input logic             done,
   input logic             err
);
   localparam int NDIG = OP_W / DIGIT_W;
   localparam int CW   = $clog2(NDIG + 1);

   logic          op_ok, bad;
   logic [CW-1:0] bcnt;

   assign op_ok = (cmd_op == 4'b0000) || (cmd_op == 4'b1000) || (cmd_op[3:2] == 2'b11);
   assign bad   = !op_ok || (cmd_acc != '0);

   always_ff @(posedge clk) begin
      if (!rst_n)    bcnt <= '0;
      else if (busy) bcnt <= bcnt + 1'b1;
      else           bcnt <= '0;
   end

   AST_ERR_ON_BAD:     assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && !busy && bad) |=> (err && !busy)); // R6
   AST_ERR_KEEPS_ACC:  assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && !busy && bad && !acc_wr_en && !acc_clr) |=> $stable(acc_out)); // R6
   AST_COND_NO_START:  assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && !busy && !bad && !cmd_cond) |=> (!busy && !err)); // R5
   AST_BUSY_BOUND:     assert property (@(posedge clk) disable iff (!rst_n) busy |-> (bcnt < CW'(NDIG))); // R7
   AST_DONE_AFTER_BUSY:assert property (@(posedge clk) disable iff (!rst_n) done |-> ($past(busy) && !busy)); // R7
   AST_DONE_PULSE:     assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
   AST_BUSY_FROZEN:    assert property (@(posedge clk) disable iff (!rst_n) busy |=> (done || $stable(acc_out))); // R10
   AST_CLEAR_ZERO:     assert property (@(posedge clk) disable iff (!rst_n) (acc_clr && !busy) |=> (acc_out == '0)); // R9
   AST_LOAD_VALUE:     assert property (@(posedge clk) disable iff (!rst_n) (acc_wr_en && !acc_clr && !busy) |=> (acc_out == $past(acc_wr_data))); // R9
endmodule

bind mac40_unit mac40_chk #(
   .ACC_W(ACC_W), .OP_W(OP_W), .DIGIT_W(DIGIT_W), .SEL_W(SEL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .cmd_acc(cmd_acc), .cmd_cond(cmd_cond), .acc_wr_en(acc_wr_en),
   .acc_wr_data(acc_wr_data), .acc_clr(acc_clr), .acc_out(acc_out),
   .busy(busy), .done(done), .err(err)
);

// File: tb/mac40_unit_tb.sv
`timescale 1ns/1ps
module mac40_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cmd_valid;
   logic [3:0]  cmd_op;
   logic [2:0]  cmd_acc;
   logic [31:0] cmd_mcand, cmd_mplier;
   logic        cmd_cond;
   logic        acc_wr_en;
   logic [39:0] acc_wr_data;
   logic        acc_clr;
   logic [39:0] acc_out;
   logic        busy, done, err;

   always #2.5 clk = ~clk;

   mac40_unit u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_acc(cmd_acc), .cmd_mcand(cmd_mcand), .cmd_mplier(cmd_mplier),
      .cmd_cond(cmd_cond), .acc_wr_en(acc_wr_en), .acc_wr_data(acc_wr_data),
      .acc_clr(acc_clr), .acc_out(acc_out), .busy(busy), .done(done), .err(err)
   );

   int          n_chk = 0;
   int          n_err = 0;
   logic [39:0] exp_acc = '0;
   logic [31:0] rng = 32'h1234_5678;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   function automatic logic [31:0] next_rng(input logic [31:0] s);
      logic [31:0] x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   function automatic logic [31:0] sx16(input logic [15:0] h);
      return {{16{h[15]}}, h};
   endfunction

   function automatic int steps_of(input logic [31:0] m);
      for (int k = 1; k <= 4; k++) begin
         logic [31:0] r = 32'($signed(m) >>> (8 * k));
         if (r == 32'h0 || r == 32'hFFFF_FFFF) return k;
      end
      return 4;
   endfunction

   function automatic logic [39:0] mul16(input logic [15:0] x, input logic [15:0] y);
      longint p = longint'($signed(x)) * longint'($signed(y));
      return p[39:0];
   endfunction

   function automatic logic legal_op(input logic [3:0] op);
      return op == 4'b0000 || op == 4'b1000 || op[3:2] == 2'b11;
   endfunction

   function automatic logic [39:0] ref_prod(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
      longint p;
      if (op == 4'b0000) begin
         p = longint'($signed(a)) * longint'($signed(b));
         return p[39:0];
      end
      if (op == 4'b1000) return mul16(a[15:0], b[15:0]) + mul16(a[31:16], b[31:16]);
      return mul16(op[1] ? a[31:16] : a[15:0], op[0] ? b[31:16] : b[15:0]);
   endfunction

   function automatic int ref_steps(input logic [3:0] op, input logic [31:0] b);
      int s0, s1;
      if (op == 4'b0000) return steps_of(b);
      if (op == 4'b1000) begin
         s0 = steps_of(sx16(b[15:0]));
         s1 = steps_of(sx16(b[31:16]));
         return (s0 > s1) ? s0 : s1;
      end
      return steps_of(sx16(op[0] ? b[31:16] : b[15:0]));
   endfunction

   function automatic string op_tag(input logic [3:0] op);
      if (op == 4'b0000) return "R2";
      if (op == 4'b1000) return "R4";
      return "R3";
   endfunction

   task automatic issue(input logic [3:0] op, input logic [2:0] sel,
                        input logic [31:0] a, input logic [31:0] b, input logic cond);
      int cnt;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_acc = sel;
      cmd_mcand = a; cmd_mplier = b; cmd_cond = cond;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      if (!legal_op(op) || sel != 3'd0) begin
         chk("R6 err raised", {63'd0, err}, 64'd1);
         chk("R6 no busy", {63'd0, busy}, 64'd0);
         @(negedge clk);
         chk("R6 err one cycle", {63'd0, err}, 64'd0);
         chk("R6 acc kept", {24'd0, acc_out}, {24'd0, exp_acc});
      end else if (!cond) begin
         chk("R5 no busy", {63'd0, busy}, 64'd0);
         chk("R5 no err", {63'd0, err}, 64'd0);
         @(negedge clk);
         chk("R5 no done", {63'd0, done}, 64'd0);
         chk("R5 acc kept", {24'd0, acc_out}, {24'd0, exp_acc});
      end else begin
         chk("R7 busy after accept", {63'd0, busy}, 64'd1);
         cnt = 0;
         while (!done && cnt < 8) begin
            @(negedge clk);
            cnt++;
         end
         chk("R7 cycle count", 64'(cnt), 64'(ref_steps(op, b)));
         chk("R7 busy low with done", {63'd0, busy}, 64'd0);
         exp_acc = exp_acc + ref_prod(op, a, b);
         chk(op_tag(op), {24'd0, acc_out}, {24'd0, exp_acc});
      end
   endtask

   task automatic load_acc(input logic [39:0] v, input logic clr);
      @(negedge clk);
      acc_wr_en = 1'b1; acc_wr_data = v; acc_clr = clr;
      @(posedge clk);
      @(negedge clk);
      acc_wr_en = 1'b0; acc_clr = 1'b0;
      exp_acc = clr ? 40'd0 : v;
      chk("R9 load/clear", {24'd0, acc_out}, {24'd0, exp_acc});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired R7 actual=hung expected=finished");
      summary();
   end

   initial begin
      logic [3:0] ops [6];
      logic [31:0] a, b;
      int cnt;
      ops = '{4'b0000, 4'b1000, 4'b1100, 4'b1101, 4'b1110, 4'b1111};
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_acc = '0;
      cmd_mcand = '0; cmd_mplier = '0; cmd_cond = 1'b0;
      acc_wr_en = 1'b0; acc_wr_data = '0; acc_clr = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 acc", {24'd0, acc_out}, 64'd0);
      chk("R1 busy", {63'd0, busy}, 64'd0);
      chk("R1 done", {63'd0, done}, 64'd0);
      chk("R1 err", {63'd0, err}, 64'd0);
      rst_n = 1'b1;

      load_acc(40'h12_3456_789A, 1'b0);
      load_acc(40'h55_5555_5555, 1'b1);   // R9 clear beats load

      // R2 wrap at 40 bits
      load_acc(40'hFF_FFFF_FFFF, 1'b0);
      issue(4'b0000, 3'd0, 32'd1, 32'd1, 1'b1);
      issue(4'b0000, 3'd0, 32'h8000_0000, 32'h8000_0000, 1'b1);
      issue(4'b0000, 3'd0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b1);

      // R7 every step count, both signs, on each code family
      for (int k = 1; k <= 4; k++) begin
         issue(4'b0000, 3'd0, 32'h0003_0405, 32'h1 << (8 * k - 2), 1'b1);
         issue(4'b0000, 3'd0, 32'hFFFE_0001, -(32'h1 << (8 * k - 2)), 1'b1);
         issue(4'b0000, 3'd0, 32'h7, (32'h1 << (8 * k - 1)), 1'b1);
      end
      issue(4'b1101, 3'd0, 32'h8000_7FFF, 32'h8000_0001, 1'b1);
      issue(4'b1000, 3'd0, 32'h7FFF_8000, 32'h0001_7F00, 1'b1);

      // R6 illegal codes and selects
      issue(4'b0100, 3'd0, 32'd3, 32'd3, 1'b1);
      issue(4'b1001, 3'd0, 32'd3, 32'd3, 1'b0);
      issue(4'b0111, 3'd0, 32'd3, 32'd3, 1'b1);
      for (int s = 1; s < 8; s++) issue(4'b0000, 3'(s), 32'd9, 32'd9, 1'b1);

      // R2 R3 R4 R5 sweep
      for (int o = 0; o < 6; o++) begin
         for (int i = 0; i < 24; i++) begin
            int sh;
            rng = next_rng(rng); a = rng;
            rng = next_rng(rng); b = rng;
            sh = (i % 4) * 8;
            b = 32'($signed(b << sh) >>> sh);
            issue(ops[o], 3'd0, a, b, (i % 7) != 3);
         end
      end

      // R8 R10 stray command, load and clear during a 4-step multiply
      load_acc(40'h00_0000_1000, 1'b0);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 4'b0000; cmd_acc = '0;
      cmd_mcand = 32'd3; cmd_mplier = 32'h4000_0000; cmd_cond = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cmd_mcand = 32'd5; cmd_mplier = 32'd5;
      acc_wr_en = 1'b1; acc_wr_data = 40'hAB_CDEF_0123; acc_clr = 1'b1;
      cnt = 0;
      while (!done && cnt < 8) begin
         @(negedge clk);
         cnt++;
      end
      cmd_valid = 1'b0; acc_wr_en = 1'b0; acc_clr = 1'b0;
      exp_acc = exp_acc + 40'h00_C000_0000;
      chk("R10 load/clear ignored while busy", {24'd0, acc_out}, {24'd0, exp_acc});
      chk("R8 first command length", 64'(cnt), 64'd4);
      @(negedge clk);
      chk("R8 stray command not started", {63'd0, busy}, 64'd0);
      @(negedge clk);
      chk("R8 no second done", {63'd0, done}, 64'd0);
      chk("R8 acc unchanged", {24'd0, acc_out}, {24'd0, exp_acc});

      summary();
   end
endmodule